// File: doc/BRIEF.md
# Enable Pulse-Count Reference Programmer

This block turns a pulse train on one enable line into a 4-bit reference setting for a regulator's reference DAC. The enable level arrives already synchronised to a free-running clock. Every qualified low pulse moves the pending setting one 25 mV step below the 0.8 V full scale. The pending setting stops at step 15, which is 425 mV.

When enable then stays high long enough, the pending setting is copied to the DAC together with a one-clock load strobe, and the counter returns to zero for the next train. While the channel is running, a new code takes effect at once, with no ramp. If enable is held low for a long time, the channel turns off. The next rising edge then loads full scale and asks the power sequencer for a soft-start.

All time windows are cycle counts given as parameters. The filter for short glitches uses the same mechanism as the long-low and long-high timers.

Top module: `enpulse_refprog`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ref_code` is 0, `dac_load` and `softstart_req` are low, and `chan_on` is low.
- R2: With the channel on, a low phase of at least GLITCH_CYC consecutive samples counts as one step. A shorter low phase is not counted.
- R3: The pending step count stops at 15. Further qualified low phases leave it at 15.
- R4: After at least one counted step, TIMEOUT_CYC consecutive high samples load the pending count into `ref_code` and raise `dac_load` for one clock. In that same clock the pending count returns to 0. `ref_code` changes only together with `dac_load`.
- R5: If no step was counted since the last load, wake or shutdown, a long high phase produces no load.
- R6: With the channel on, OFF_CYC consecutive low samples drop `chan_on`, discard the pending count and leave `ref_code` unchanged.
- R7: The first high sample while the channel is off sets `ref_code` to 0 (full scale), raises `dac_load` and `softstart_req` for one clock, and raises `chan_on`.
- R8: A load issued while the channel is on leaves `softstart_req` low and `chan_on` high.
- R9: `softstart_req` is only ever high together with `dac_load` and `ref_code` equal to 0.

Code encoding: 0 is 0.8 V, and each code step is 25 mV lower, down to 15 = 425 mV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| en_lvl | input | 1 | Synchronised enable level |
| ref_code | output | 4 | Latched reference code for the DAC |
| dac_load | output | 1 | One-clock strobe: DAC takes `ref_code` |
| softstart_req | output | 1 | One-clock request to ramp from full scale |
| chan_on | output | 1 | Channel running (not in long-low shutdown) |

## Verification
The DAC load is one function and the counter rearm is another, and both act in the clock where the high timeout expires. The bench provokes this by following a timed-out train directly with a fresh pulse train. It expects the second load to carry only the new count, which shows the counter was cleared in the latch clock and not merely copied.

A second pair lands together when a qualified low phase reaches the saturation ceiling, so that the step and the clamp share a cycle. Sending twenty pulses must yield code 15. The boundary widths of GLITCH_CYC and GLITCH_CYC-1, a high phase of TIMEOUT_CYC-1, and a low hold of OFF_CYC-1 are each judged by the exact code loaded afterwards.

// File: rtl/refprog_pkg.sv
package refprog_pkg;
    localparam int CODE_W   = 4;
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t code;   // latched DAC code
        logic  load;   // one-clock load strobe
        logic  ss;     // one-clock soft-start request
        logic  on;     // channel running
        logic  armed;  // a step was counted since last latch
    } ctl_t;
endpackage

// File: rtl/refprog_runlen.sv
module refprog_runlen #(
    parameter int SAT = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       match,
    output logic [$clog2(SAT+1)-1:0]   run_q
);
    localparam int W = $clog2(SAT + 1);
    localparam logic [W-1:0] SAT_V = W'(SAT);

    logic [W-1:0] run_d;

    always_comb begin
        if (!match)
            run_d = '0;
        else if (run_q == SAT_V)
            run_d = run_q;
        else
            run_d = run_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= run_d;
    end
endmodule

// File: rtl/refprog_stepcnt.sv
module refprog_stepcnt
    import refprog_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  clr,
    output code_t val_q
);
    localparam code_t TOP = code_t'(CODE_MAX);

    code_t val_d;

    always_comb begin
        val_d = val_q;
        if (clr)
            val_d = '0;
        else if (step && val_q != TOP)
            val_d = val_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= val_d;
    end
endmodule

// File: rtl/enpulse_refprog.sv
module enpulse_refprog
    import refprog_pkg::*;
#(
    parameter int GLITCH_CYC  = 6,
    parameter int TIMEOUT_CYC = 12500,
    parameter int OFF_CYC     = 17000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_lvl,
    output logic [CODE_W-1:0] ref_code,
    output logic              dac_load,
    output logic              softstart_req,
    output logic              chan_on
);
    localparam int HI_W = $clog2(TIMEOUT_CYC + 1);
    localparam int LO_W = $clog2(OFF_CYC + 1);
    localparam logic [HI_W-1:0] HI_LAST  = HI_W'(TIMEOUT_CYC - 1);
    localparam logic [LO_W-1:0] LO_QUAL  = LO_W'(GLITCH_CYC - 1);
    localparam logic [LO_W-1:0] LO_LAST  = LO_W'(OFF_CYC - 1);

    logic [HI_W-1:0] hi_run;
    logic [LO_W-1:0] lo_run;
    code_t           pending;
    ctl_t            st_d, st_q;
    logic            wake, off_hit, latch, fall_ok, step, clr;

    refprog_runlen #(.SAT(TIMEOUT_CYC)) u_hi (
        .clk(clk), .rst(rst), .match(en_lvl), .run_q(hi_run)
    );

    refprog_runlen #(.SAT(OFF_CYC)) u_lo (
        .clk(clk), .rst(rst), .match(!en_lvl), .run_q(lo_run)
    );

    refprog_stepcnt u_cnt (
        .clk(clk), .rst(rst), .step(step), .clr(clr), .val_q(pending)
    );

    // event decode
    always_comb begin
        wake    = en_lvl && !st_q.on;
        off_hit = !en_lvl && st_q.on && (lo_run == LO_LAST);
        fall_ok = !en_lvl && st_q.on && (lo_run == LO_QUAL);
        latch   = en_lvl && st_q.on && st_q.armed && (hi_run == HI_LAST);
        step    = fall_ok;
        clr     = wake || off_hit || latch;
    end

    // next-state
    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        st_d.ss   = 1'b0;
        if (wake) begin
            st_d.code  = '0;
            st_d.load  = 1'b1;
            st_d.ss    = 1'b1;
            st_d.on    = 1'b1;
            st_d.armed = 1'b0;
        end else if (off_hit) begin
            st_d.on    = 1'b0;
            st_d.armed = 1'b0;
        end else if (latch) begin
            st_d.code  = pending;
            st_d.load  = 1'b1;
            st_d.armed = 1'b0;
        end else if (fall_ok) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ref_code      = st_q.code;
    assign dac_load      = st_q.load;
    assign softstart_req = st_q.ss;
    assign chan_on       = st_q.on;
endmodule

// File: rtl/refprog_chk.sv
module refprog_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_lvl,
    input logic [3:0] ref_code,
    input logic       dac_load,
    input logic       softstart_req,
    input logic       chan_on
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (ref_code == 4'd0 && !dac_load && !softstart_req && !chan_on));

    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_code != $past(ref_code)) |-> dac_load);

    // R4
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dac_load |=> !dac_load);

    // R9
    ss_pair_chk: assert property (@(posedge clk) disable iff (rst)
        softstart_req |-> (dac_load && ref_code == 4'd0));

    // R7
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chan_on) |-> softstart_req);

    // R6
    off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(chan_on) |-> (!dac_load && !$past(en_lvl)));

    // R8
    run_load_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_load && !softstart_req) |-> ($past(chan_on) && chan_on));
endmodule

bind enpulse_refprog refprog_chk u_chk (
    .clk(clk), .rst(rst), .en_lvl(en_lvl), .ref_code(ref_code),
    .dac_load(dac_load), .softstart_req(softstart_req), .chan_on(chan_on)
);

// File: tb/tb_enpulse_refprog.sv
module tb_enpulse_refprog;
    localparam int G = 4;
    localparam int T = 40;
    localparam int O = 60;

    typedef struct {
        logic [3:0] code;
        logic       ss;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_lvl = 1'b0;
    logic [3:0] ref_code;
    logic       dac_load, softstart_req, chan_on;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    item_t expq[$];

    always #5 clk = ~clk;

    enpulse_refprog #(.GLITCH_CYC(G), .TIMEOUT_CYC(T), .OFF_CYC(O)) dut (
        .clk(clk), .rst(rst), .en_lvl(en_lvl), .ref_code(ref_code),
        .dac_load(dac_load), .softstart_req(softstart_req), .chan_on(chan_on)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic s, input string req);
        item_t it;
        it.code = c; it.ss = s; it.req = req;
        expq.push_back(it);
    endtask

    task automatic hold(input logic v, input int n);
        en_lvl = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic train(input int cnt, input int lo, input int hi);
        for (int i = 0; i < cnt; i++) begin
            hold(1'b0, lo);
            hold(1'b1, hi);
        end
    endtask

    // monitor: compare each load against the scoreboard
    always @(negedge clk) begin
        if (!rst && dac_load) begin
            if (expq.size() == 0) begin
                checks++; fails++;
                $display("FAIL R5: unexpected load code %0d ss %0b, expected none",
                         ref_code, softstart_req);
            end else begin
                item_t it;
                it = expq.pop_front();
                chk({it.req, " code"}, ref_code, it.code);
                chk({it.req, " softstart"}, softstart_req, it.ss);
                if (!it.ss) chk("R8 chan_on at run load", chan_on, 1);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 code", ref_code, 0);
        chk("R1 load", dac_load, 0);
        chk("R1 chan_on", chan_on, 0);

        // R7 wake from off, then R5 unarmed timeout gives nothing
        push(4'd0, 1'b1, "R7 wake");
        hold(1'b1, T + 10);
        chk("R7 chan_on", chan_on, 1);

        // main function: three pulses
        push(4'd3, 1'b0, "R4 three steps");
        train(3, G + 1, 10);
        hold(1'b1, T);
        chk("R4 code after latch", ref_code, 3);

        // R2 glitches rejected among valid pulses
        push(4'd2, 1'b0, "R2 glitch filter");
        train(2, G - 2, 10);
        train(2, G + 2, 10);
        hold(1'b1, T);

        // R3 saturation with twenty pulses
        push(4'd15, 1'b0, "R3 saturate");
        train(20, G, 6);
        hold(1'b1, T);
        chk("R3 code", ref_code, 15);

        // R2 boundary widths G and G-1
        push(4'd1, 1'b0, "R2 width boundary");
        train(1, G, 10);
        train(1, G - 1, 10);
        hold(1'b1, T);

        // R4 high phase of T-1 does not latch; exact T does
        push(4'd2, 1'b0, "R4 timeout boundary");
        hold(1'b0, G + 1); hold(1'b1, T - 1);
        hold(1'b0, G + 1); hold(1'b1, T);
        // rearm in the latch clock: next train counts from zero
        push(4'd1, 1'b0, "R4 rearm");
        train(1, G + 1, 10);
        hold(1'b1, T);
        chk("R4 rearm code", ref_code, 1);

        // R6 long low: off, code held
        hold(1'b0, O);
        chk("R6 chan_on", chan_on, 0);
        chk("R6 code held", ref_code, 1);
        push(4'd0, 1'b1, "R7 rewake");
        hold(1'b1, T + 5);

        // R6 boundary: O-1 low is a counted step, not shutdown
        push(4'd1, 1'b0, "R6 low boundary");
        hold(1'b0, O - 1);
        chk("R6 still on", chan_on, 1);
        hold(1'b1, T + 2);

        // R6 pending discarded by shutdown
        train(3, G + 1, 10);
        hold(1'b0, O);
        chk("R6 off after train", chan_on, 0);
        push(4'd0, 1'b1, "R7 wake after discard");
        hold(1'b1, T + 5);
        chk("R6 code full scale", ref_code, 0);

        chk("R4 scoreboard drained", expq.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule